// File: doc/BRIEF.md
# Subgroup Lane Permute Crossbar

This block moves 32-bit values between the sixteen lanes of a thread group in one step. Every lane offers a value, says whether it is active, and names a selector. The crossbar turns each lane's selector into a source lane and hands that lane's value back to the requester. The whole group can be split into aligned subgroups of 2, 4, 8 or 16 lanes. A lane never reads outside its own subgroup.

A shared lane-operation code sets how a selector becomes a source lane:

- Direct indexing.
- Exclusive-or with the lane's own position.
- A rotating shift.
- A backward step used to build prefix reductions.

If the source lane is inactive, or a backward step runs off the start of the subgroup, the requester gets a constant instead. That constant comes from a fixed table of sixteen useful values, picked by a 4-bit code.

Inputs are captured on a valid strobe. Results come out of registers one clock later, together with a per-lane flag that marks which results belong to active requesters.

Top module: `lane_xbar`

## Requirements
- R1: While reset is high, and after it falls until the first strobe, `res_valid`, `res_data` and `res_lane_ok` are all zero.
- R2: `res_valid` is high in exactly the cycle after a cycle with `req_valid` high. Without a strobe, `res_data` and `res_lane_ok` keep their values.
- R3: `grp_size` 0, 1, 2 and 3 selects subgroups of 2, 4, 8 and 16 lanes, aligned to multiples of their size. A lane's source lane always lies in its own subgroup. Within the subgroup, the lane's offset is its lane number modulo the size.
- R4: With `lane_op` = 0 (direct), the source offset is the selector modulo the subgroup size.
- R5: With `lane_op` = 1 (exclusive-or), the source offset is (own offset XOR selector) modulo the subgroup size.
- R6: With `lane_op` = 3 (shift), the source offset is (own offset + selector) modulo the subgroup size.
- R7: With `lane_op` = 2 (accumulate), the source offset is own offset minus selector. If the selector is larger than the own offset, the lane receives the substitute constant.
- R8: When the source lane is inactive, an active requester receives the substitute constant chosen by `fill_code`. Codes 0 to 15 map, in order, to: 00000000, FFFFFFFF, 00000001, 00010001, 80000000, 7FFFFFFF, 80008000, 7FFF7FFF, 80808080, 7F7F7F7F, 3F800000, 3C003C00, FF800000, 7F800000, FC00FC00, 7C007C00 (hex).
- R9: An inactive requester receives zero and has its `res_lane_ok` bit low. An active requester has its bit high.
- R10: `grp_size`, `lane_op`, `fill_code` and all lane inputs are sampled only on the strobe. Changing them between strobes does not alter the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Strobe that samples all request inputs |
| req_data | input | 512 | Lane values, lane n in bits [32n+31:32n] |
| req_active | input | 16 | Active bit per lane |
| req_sel | input | 64 | Selector per lane, lane n in bits [4n+3:4n] |
| grp_size | input | 2 | Subgroup size code |
| lane_op | input | 2 | Lane-operation code |
| fill_code | input | 4 | Substitute constant code |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_data | output | 512 | Permuted values, same lane packing as `req_data` |
| res_lane_ok | output | 16 | Per-lane flag: requester was active |

## Verification
The hardest case to reach from the ports is a wrapped or rejected index. Examples are a shift that crosses the top of a small subgroup, or a backward step whose selector is exactly one more than the lane's offset. Either case must land on, or just miss, an inactive lane in the same subgroup.

The stimulus reaches these cases by sweeping every subgroup size, lane operation and fill code. Each combination uses several activity masks and selector patterns, so sixteen full-width lanes meet both in-range and out-of-range indices with active and inactive sources.

After every strobe, the inputs are scrambled and the results are checked again, to show that they are held.

// File: rtl/lane_xbar_pkg.sv
package lane_xbar_pkg;

  typedef enum logic [1:0] {
    GRP_2  = 2'd0,
    GRP_4  = 2'd1,
    GRP_8  = 2'd2,
    GRP_16 = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    OP_DIRECT = 2'd0,
    OP_XOR    = 2'd1,
    OP_ACCUM  = 2'd2,
    OP_ROTATE = 2'd3
  } lane_op_e;

  // Substitute constant for reads that find no usable source lane.
  function automatic logic [31:0] fill_value(input logic [3:0] code);
    logic [31:0] v;
    case (code)
      4'd0:    v = 32'h0000_0000;
      4'd1:    v = 32'hFFFF_FFFF;
      4'd2:    v = 32'h0000_0001;
      4'd3:    v = 32'h0001_0001;
      4'd4:    v = 32'h8000_0000;
      4'd5:    v = 32'h7FFF_FFFF;
      4'd6:    v = 32'h8000_8000;
      4'd7:    v = 32'h7FFF_7FFF;
      4'd8:    v = 32'h8080_8080;
      4'd9:    v = 32'h7F7F_7F7F;
      4'd10:   v = 32'h3F80_0000;
      4'd11:   v = 32'h3C00_3C00;
      4'd12:   v = 32'hFF80_0000;
      4'd13:   v = 32'h7F80_0000;
      4'd14:   v = 32'hFC00_FC00;
      default: v = 32'h7C00_7C00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/lane_xbar_index.sv
module lane_xbar_index
  import lane_xbar_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int LANE_ID = 0,
  localparam int LW     = $clog2(LANES)
) (
  input  logic [LW-1:0] sel,
  input  logic [1:0]    grp,
  input  logic [1:0]    op,
  output logic [LW-1:0] src,
  output logic          oob
);

  logic [LW-1:0] mask;
  logic [LW-1:0] own;
  logic [LW-1:0] off;
  logic [LW-1:0] base;
  logic [LW-1:0] off_src;

  always_comb begin
    mask    = LW'((32'd2 << grp) - 32'd1);
    own     = LW'(LANE_ID);
    off     = own & mask;
    base    = own & ~mask;
    oob     = 1'b0;
    off_src = '0;
    case (lane_op_e'(op))
      OP_DIRECT: off_src = sel & mask;
      OP_XOR:    off_src = (off ^ sel) & mask;
      OP_ACCUM: begin
        oob     = (sel > off);
        off_src = (off - sel) & mask;
      end
      default:   off_src = (off + sel) & mask;
    endcase
    src = base | off_src;
  end

endmodule

// File: rtl/lane_xbar_pick.sv
module lane_xbar_pick
  import lane_xbar_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 32,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] data_all,
  input  logic [LANES-1:0]    active_all,
  input  logic [LW-1:0]       src,
  input  logic                oob,
  input  logic                self_active,
  input  logic [3:0]          fill_code,
  output logic [DW-1:0]       val
);

  logic [DW-1:0] picked;
  logic          src_active;

  always_comb begin
    picked     = '0;
    src_active = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (src == LW'(j)) begin
        picked     = data_all[j*DW +: DW];
        src_active = active_all[j];
      end
    end
    if (!self_active)
      val = '0;
    else if (oob || !src_active)
      val = DW'(fill_value(fill_code));
    else
      val = picked;
  end

endmodule

// File: rtl/lane_xbar.sv
module lane_xbar
  import lane_xbar_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 32,
  localparam int LW   = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [LANES*DW-1:0] req_data,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*LW-1:0] req_sel,
  input  logic [1:0]          grp_size,
  input  logic [1:0]          lane_op,
  input  logic [3:0]          fill_code,
  output logic                res_valid,
  output logic [LANES*DW-1:0] res_data,
  output logic [LANES-1:0]    res_lane_ok
);

  logic [LW-1:0] src_lane [LANES];
  logic [LANES-1:0] oob;
  logic [DW-1:0] lane_val [LANES];
  logic [LW-1:0] grp_mask;

  assign grp_mask = LW'((32'd2 << grp_size) - 32'd1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_xbar_index #(.LANES(LANES), .LANE_ID(i)) u_idx (
      .sel (req_sel[i*LW +: LW]),
      .grp (grp_size),
      .op  (lane_op),
      .src (src_lane[i]),
      .oob (oob[i])
    );

    lane_xbar_pick #(.LANES(LANES), .DW(DW)) u_pick (
      .data_all    (req_data),
      .active_all  (req_active),
      .src         (src_lane[i]),
      .oob         (oob[i]),
      .self_active (req_active[i]),
      .fill_code   (fill_code),
      .val         (lane_val[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        res_data[i*DW +: DW] <= '0;
        res_lane_ok[i]       <= 1'b0;
      end else if (req_valid) begin
        res_data[i*DW +: DW] <= lane_val[i];
        res_lane_ok[i]       <= req_active[i];
      end
    end

    AST_SRC_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> (((src_lane[i] ^ LW'(i)) & ~grp_mask) == '0)); // R3
    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_lane_ok[i]) |-> (res_data[i*DW +: DW] == '0)); // R9
  end

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= req_valid;
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid); // R2
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(res_data) && $stable(res_lane_ok))); // R10
  AST_OK_TRACKS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (res_lane_ok == $past(req_active))); // R9

endmodule

// File: tb/test_lane_xbar.sv
module test_lane_xbar;

  localparam int LANES = 16;
  localparam int DW    = 32;
  localparam int LW    = 4;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                req_valid = 1'b0;
  logic [LANES*DW-1:0] req_data = '0;
  logic [LANES-1:0]    req_active = '0;
  logic [LANES*LW-1:0] req_sel = '0;
  logic [1:0]          grp_size = '0;
  logic [1:0]          lane_op = '0;
  logic [3:0]          fill_code = '0;
  logic                res_valid;
  logic [LANES*DW-1:0] res_data;
  logic [LANES-1:0]    res_lane_ok;

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5679;

  always #5 clk = ~clk;

  lane_xbar #(.LANES(LANES), .DW(DW)) i_lane_xbar (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data),
    .req_active(req_active), .req_sel(req_sel), .grp_size(grp_size),
    .lane_op(lane_op), .fill_code(fill_code), .res_valid(res_valid),
    .res_data(res_data), .res_lane_ok(res_lane_ok)
  );

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [31:0] table_val(input int f);
    case (f)
      0: return 32'h00000000;  1: return 32'hFFFFFFFF;
      2: return 32'h00000001;  3: return 32'h00010001;
      4: return 32'h80000000;  5: return 32'h7FFFFFFF;
      6: return 32'h80008000;  7: return 32'h7FFF7FFF;
      8: return 32'h80808080;  9: return 32'h7F7F7F7F;
      10: return 32'h3F800000; 11: return 32'h3C003C00;
      12: return 32'hFF800000; 13: return 32'h7F800000;
      14: return 32'hFC00FC00; default: return 32'h7C007C00;
    endcase
  endfunction

  // Reference model written from R3..R9.
  function automatic logic [31:0] model(input int l, input int g, input int op,
                                        input int f, input logic [15:0] act,
                                        input logic [63:0] sel,
                                        input logic [511:0] dat,
                                        output string tag);
    int size, base, off, s, src;
    size = 2 << g;
    base = (l / size) * size;
    off  = l % size;
    s    = int'(sel[l*4 +: 4]);
    if (!act[l]) begin tag = "R9"; return 32'h0; end
    case (op)
      0: begin tag = "R4"; src = s % size; end
      1: begin tag = "R5"; src = (off ^ s) % size; end
      2: begin
        tag = "R7";
        if (s > off) return table_val(f);
        src = off - s;
      end
      default: begin tag = "R6"; src = (off + s) % size; end
    endcase
    src = src + base;
    if (!act[src]) begin tag = "R8"; return table_val(f); end
    return dat[src*32 +: 32];
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input int g, input int op, input int f, input int pat);
    logic [511:0] dat;
    logic [15:0]  act;
    logic [63:0]  sel;
    logic [511:0] held;
    logic [15:0]  held_ok;
    string tag;
    logic [31:0] e;
    for (int l = 0; l < LANES; l++) begin
      rng = next_rng(rng);
      dat[l*32 +: 32] = {8'hD0 + 8'(l), rng[23:0]};
      case (pat)
        0: sel[l*4 +: 4] = 4'(l + 1);
        1: sel[l*4 +: 4] = 4'(l % 3);
        default: sel[l*4 +: 4] = rng[27:24];
      endcase
    end
    rng = next_rng(rng);
    act = (pat == 0) ? 16'hFFFF : rng[15:0];
    @(negedge clk);
    req_data = dat; req_active = act; req_sel = sel;
    grp_size = 2'(g); lane_op = 2'(op); fill_code = 4'(f);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid == 1'b1, "R2 valid", {511'b0, res_valid}, 512'd1);
    for (int l = 0; l < LANES; l++) begin
      e = model(l, g, op, f, act, sel, dat, tag);
      check(res_data[l*32 +: 32] == e, {tag, "/R3 data"},
            {480'b0, res_data[l*32 +: 32]}, {480'b0, e});
      check(res_lane_ok[l] == act[l], "R9 lane_ok",
            {511'b0, res_lane_ok[l]}, {511'b0, act[l]});
    end
    held = res_data; held_ok = res_lane_ok;
    // scramble inputs without a strobe
    req_data = ~dat; req_active = ~act; req_sel = ~sel;
    grp_size = ~grp_size; lane_op = ~lane_op; fill_code = ~fill_code;
    @(negedge clk);
    check(res_valid == 1'b0, "R2 no strobe", {511'b0, res_valid}, 512'd0);
    check(res_data == held && res_lane_ok == held_ok, "R10 hold",
          res_data, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0 && res_data == '0 && res_lane_ok == '0, "R1 reset",
          res_data, 512'd0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && res_data == '0 && res_lane_ok == '0, "R1 idle",
          res_data, 512'd0);
    for (int g = 0; g < 4; g++)
      for (int op = 0; op < 4; op++)
        for (int f = 0; f < 16; f++)
          for (int p = 0; p < 3; p++)
            run_vec(g, op, f, p);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule